// File: doc/BRIEF.md
# Banked Window and Coprocessor Run-Mode Controller

This block lets a slow host processor supervise a fast coprocessor that owns 64 KB of RAM of its own. The RAM is treated as eight banks of 8 KB. The host sees one bank at a time through a fixed 8 KB window at host addresses 0x6000 to 0x7FFF. A bank register picks which bank the window shows. When bank 7 is selected, host addresses 0x7FFA to 0x7FFF land on the coprocessor's interrupt and reset vectors at 0xFFFA to 0xFFFF.

A mode register sets how the coprocessor advances. It can be held in reset, stopped, free-running at full speed, locked to the host's 1 MHz bus clock, or single-stepped by the host. The block drives the coprocessor's clock-enable and reset. It also arbitrates the single RAM port between the host window and the coprocessor's bus requests.

The usual sequence is as follows. The host stops or resets the coprocessor. It then fills the vectors, zero page, stack and program through the window. Finally it writes a run mode.

Top module: `cop_supervisor`

## Requirements
- R1: After reset the mode is 0 (reset): `cop_rst_no` is low and `cop_ce_o` is low. While the mode is 0, `cop_rst_no` stays low from the following cycle. A read of the mode register returns 0x00.
- R2: A host access with `host_addr_i[15:13]` = 3'b011 (window 0x6000-0x7FFF) goes to RAM address {bank, `host_addr_i[12:0]`} in the same cycle. With bank 7, host 0x7FFC reaches coprocessor address 0xFFFC.
- R3: A host write to 0x9C00 sets the bank to `wdata[2:0]`. A read of 0x9C00 returns {5'b0, bank}.
- R4: Mode 1 (stopped) and the unused codes 5, 6 and 7 give no clock-enable and release reset. A coprocessor write issued while stopped does not reach RAM.
- R5: In mode 2 (free-run), `cop_ce_o` is high in every cycle without an arbitration conflict.
- R6: In mode 3 (sync), `host_clk_i` passes through a two-stage synchronizer. Each rising edge of `host_clk_i` gives exactly one clock-enable cycle.
- R7: A host write of the value 4 to the mode register (0x9C01) gives exactly one clock-enable cycle. The coprocessor then holds until the next such write.
- R8: A conflict is a host window access and a coprocessor request in the same cycle. In a conflict the host gets the RAM and `cop_ce_o` is low. A clock-enable that was due in sync or step mode is postponed, not lost.
- R9: The coprocessor reaches RAM at its full 16-bit address only in cycles where `cop_ce_o` is high. Its read data appears on `cop_rdata_o` in the next cycle.
- R10: A read of the mode register returns {`cop_ce_o` in the request cycle, 4'b0, mode[2:0]} in the next cycle. Host read data is always valid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | Host write when high |
| host_addr_i | input | 16 | Host address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid the cycle after the request |
| host_clk_i | input | 1 | Host 1 MHz bus clock, asynchronous |
| cop_req_i | input | 1 | Coprocessor bus request |
| cop_we_i | input | 1 | Coprocessor write when high |
| cop_addr_i | input | 16 | Coprocessor address |
| cop_wdata_i | input | 8 | Coprocessor write data |
| cop_rdata_o | output | 8 | Coprocessor read data, one cycle after an enabled request |
| cop_ce_o | output | 1 | Coprocessor clock-enable |
| cop_rst_no | output | 1 | Coprocessor reset, active low |
| ram_en_o | output | 1 | RAM access strobe |
| ram_we_o | output | 1 | RAM write |
| ram_addr_o | output | 16 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the strobe |

## Verification
The assertions check the cycle-local rules on every clock:
- reset is held while the mode is 0;
- the stopped and unused codes never enable the coprocessor;
- free-run enables in every cycle without a conflict;
- the host wins a conflict and drives the mapped address;
- a coprocessor access reaches RAM only with its enable.

Only the bench scenarios can show the counting behaviours. These are one enable per host-clock edge and one per step command. They also include a postponed step that is not lost and the readback values. The bench also shows that data written on one side of the shared RAM is seen on the other, including the vector area through bank 7.

// File: rtl/cop_sup_pkg.sv
`timescale 1ns/1ps
package cop_sup_pkg;
  typedef enum logic [2:0] {
    MODE_RESET = 3'd0,
    MODE_STOP  = 3'd1,
    MODE_FREE  = 3'd2,
    MODE_SYNC  = 3'd3,
    MODE_STEP  = 3'd4
  } run_mode_e;
endpackage

// File: rtl/cop_sup_regs.sv
`timescale 1ns/1ps
module cop_sup_regs #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 3,
  parameter logic [AW-1:0] BANK_ADDR = 16'h9C00,
  parameter logic [AW-1:0] MODE_ADDR = 16'h9C01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ce_i,
  output logic [BW-1:0] bank_o,
  output logic [2:0]    mode_o,
  output logic          step_o,
  output logic [DW-1:0] rd_o
);
  import cop_sup_pkg::*;

  logic hit_bank, hit_mode;
  assign hit_bank = req_i && (addr_i == BANK_ADDR);
  assign hit_mode = req_i && (addr_i == MODE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
      mode_o <= MODE_RESET;
      step_o <= 1'b0;
      rd_o   <= '0;
    end else begin
      step_o <= hit_mode && we_i && (wdata_i == DW'(MODE_STEP));
      if (hit_bank && we_i) bank_o <= wdata_i[BW-1:0];
      if (hit_mode && we_i) mode_o <= wdata_i[2:0];
      if (hit_bank && !we_i)      rd_o <= {{(DW-BW){1'b0}}, bank_o};
      else if (hit_mode && !we_i) rd_o <= {ce_i, {(DW-4){1'b0}}, mode_o};
      else                        rd_o <= '0;
    end
  end
endmodule

// File: rtl/cop_sup_runctl.sv
`timescale 1ns/1ps
module cop_sup_runctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       step_i,
  input  logic       host_clk_i,
  input  logic       conflict_i,
  output logic       ce_o,
  output logic       rst_no
);
  import cop_sup_pkg::*;

  // extra stage holds the previous synchronised level for edge detect
  logic [SYNC_STAGES:0] sync_q;
  logic                 host_rise, tick, pend_q, paced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], host_clk_i};
  end
  assign host_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  assign paced = (mode_i == MODE_SYNC) || (mode_i == MODE_STEP);
  assign tick  = ((mode_i == MODE_SYNC) && host_rise) ||
                 ((mode_i == MODE_STEP) && step_i);

  always_comb begin
    if (mode_i == MODE_FREE) ce_o = !conflict_i;
    else if (paced)          ce_o = (tick || pend_q) && !conflict_i;
    else                     ce_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rst_no <= 1'b0;
    end else begin
      pend_q <= paced && (tick || pend_q) && conflict_i;
      rst_no <= (mode_i != MODE_RESET);
    end
  end
endmodule

// File: rtl/cop_sup_arb.sv
`timescale 1ns/1ps
module cop_sup_arb #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int BW  = 3,
  parameter int OW  = 13,
  parameter logic [AW-1:0] WIN_BASE = 16'h6000,
  localparam int RAW = BW + OW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_req_i,
  input  logic           host_we_i,
  input  logic [AW-1:0]  host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  input  logic [BW-1:0]  bank_i,
  input  logic           cop_req_i,
  input  logic           cop_we_i,
  input  logic [RAW-1:0] cop_addr_i,
  input  logic [DW-1:0]  cop_wdata_i,
  input  logic           cop_ce_i,
  output logic           conflict_o,
  output logic           host_ram_q,
  output logic           ram_en_o,
  output logic           ram_we_o,
  output logic [RAW-1:0] ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o
);
  logic host_win;
  assign host_win   = host_req_i && (host_addr_i[AW-1:OW] == WIN_BASE[AW-1:OW]);
  assign conflict_o = host_win && cop_req_i;

  always_comb begin
    if (host_win) begin
      ram_en_o    = 1'b1;
      ram_we_o    = host_we_i;
      ram_addr_o  = {bank_i, host_addr_i[OW-1:0]};
      ram_wdata_o = host_wdata_i;
    end else begin
      ram_en_o    = cop_req_i && cop_ce_i;
      ram_we_o    = cop_req_i && cop_ce_i && cop_we_i;
      ram_addr_o  = cop_addr_i;
      ram_wdata_o = cop_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_ram_q <= 1'b0;
    else         host_ram_q <= host_win && !host_we_i;
  end
endmodule

// File: rtl/cop_supervisor.sv
`timescale 1ns/1ps
module cop_supervisor #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BANKS = 8,
  parameter int BANK_BYTES = 8192,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] WIN_BASE  = 16'h6000,
  parameter logic [AW-1:0] BANK_ADDR = 16'h9C00,
  parameter logic [AW-1:0] MODE_ADDR = 16'h9C01,
  localparam int BW  = $clog2(BANKS),
  localparam int OW  = $clog2(BANK_BYTES),
  localparam int RAW = BW + OW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           host_req_i,
  input  logic           host_we_i,
  input  logic [AW-1:0]  host_addr_i,
  input  logic [DW-1:0]  host_wdata_i,
  output logic [DW-1:0]  host_rdata_o,
  input  logic           host_clk_i,
  input  logic           cop_req_i,
  input  logic           cop_we_i,
  input  logic [RAW-1:0] cop_addr_i,
  input  logic [DW-1:0]  cop_wdata_i,
  output logic [DW-1:0]  cop_rdata_o,
  output logic           cop_ce_o,
  output logic           cop_rst_no,
  output logic           ram_en_o,
  output logic           ram_we_o,
  output logic [RAW-1:0] ram_addr_o,
  output logic [DW-1:0]  ram_wdata_o,
  input  logic [DW-1:0]  ram_rdata_i
);
  logic [BW-1:0] bank_q;
  logic [2:0]    mode_q;
  logic          step_q, conflict, host_ram_q;
  logic [DW-1:0] reg_rd_q;

  cop_sup_regs #(
    .AW(AW), .DW(DW), .BW(BW), .BANK_ADDR(BANK_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(host_req_i), .we_i(host_we_i),
    .addr_i(host_addr_i), .wdata_i(host_wdata_i), .ce_i(cop_ce_o),
    .bank_o(bank_q), .mode_o(mode_q), .step_o(step_q), .rd_o(reg_rd_q)
  );

  cop_sup_runctl #(.SYNC_STAGES(SYNC_STAGES)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_q), .step_i(step_q),
    .host_clk_i(host_clk_i), .conflict_i(conflict),
    .ce_o(cop_ce_o), .rst_no(cop_rst_no)
  );

  cop_sup_arb #(
    .AW(AW), .DW(DW), .BW(BW), .OW(OW), .WIN_BASE(WIN_BASE)
  ) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_req_i(host_req_i), .host_we_i(host_we_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i), .bank_i(bank_q),
    .cop_req_i(cop_req_i), .cop_we_i(cop_we_i), .cop_addr_i(cop_addr_i),
    .cop_wdata_i(cop_wdata_i), .cop_ce_i(cop_ce_o),
    .conflict_o(conflict), .host_ram_q(host_ram_q),
    .ram_en_o(ram_en_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o)
  );

  assign host_rdata_o = host_ram_q ? ram_rdata_i : reg_rd_q;
  assign cop_rdata_o  = ram_rdata_i;
endmodule

// File: rtl/cop_supervisor_chk.sv
`timescale 1ns/1ps
module cop_supervisor_chk #(
  parameter int AW = 16,
  parameter int BW = 3,
  parameter int OW = 13,
  parameter logic [AW-1:0] WIN_BASE = 16'h6000,
  localparam int RAW = BW + OW
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           host_req_i,
  input logic [AW-1:0]  host_addr_i,
  input logic           cop_req_i,
  input logic           cop_ce_o,
  input logic           cop_rst_no,
  input logic           ram_en_o,
  input logic [RAW-1:0] ram_addr_o,
  input logic [BW-1:0]  bank_q,
  input logic [2:0]     mode_q
);
  logic win;
  assign win = host_req_i && (host_addr_i[AW-1:OW] == WIN_BASE[AW-1:OW]);

  a_r1_reset_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0) |=> !cop_rst_no);

  a_r1_no_ce_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd0) |-> !cop_ce_o);

  a_r4_stopped_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd1 || mode_q >= 3'd5) |-> !cop_ce_o);

  a_r5_free_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd2 && !(win && cop_req_i)) |-> cop_ce_o);

  a_r8_host_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win && cop_req_i) |-> (!cop_ce_o && ram_addr_o == {bank_q, host_addr_i[OW-1:0]}));

  a_r9_cop_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_en_o && !win) |-> (cop_ce_o && cop_req_i));
endmodule

bind cop_supervisor cop_supervisor_chk #(
  .AW(AW), .BW(BW), .OW(OW), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_req_i(host_req_i),
  .host_addr_i(host_addr_i), .cop_req_i(cop_req_i), .cop_ce_o(cop_ce_o),
  .cop_rst_no(cop_rst_no), .ram_en_o(ram_en_o), .ram_addr_o(ram_addr_o),
  .bank_q(bank_q), .mode_q(mode_q)
);

// File: tb/cop_supervisor_tb.sv
`timescale 1ns/1ps
module cop_supervisor_tb;
  localparam logic [15:0] BANK_A = 16'h9C00;
  localparam logic [15:0] MODE_A = 16'h9C01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 0, host_we = 0, host_clk = 0;
  logic [15:0] host_addr = 0, cop_addr = 0;
  logic [7:0]  host_wdata = 0, cop_wdata = 0;
  logic cop_req = 0, cop_we = 0;
  logic [7:0] host_rdata, cop_rdata, ram_wdata, ram_rdata;
  logic cop_ce, cop_rst_n, ram_en, ram_we;
  logic [15:0] ram_addr;

  int total = 0, bad = 0, ce_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cop_supervisor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .host_clk_i(host_clk), .cop_req_i(cop_req), .cop_we_i(cop_we),
    .cop_addr_i(cop_addr), .cop_wdata_i(cop_wdata), .cop_rdata_o(cop_rdata),
    .cop_ce_o(cop_ce), .cop_rst_no(cop_rst_n), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // sparse RAM model: bank bits plus low 9 offset bits
  logic [7:0] mem [4096];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[{ram_addr[15:13], ram_addr[8:0]}] <= ram_wdata;
      ram_rdata <= mem[{ram_addr[15:13], ram_addr[8:0]}];
    end
  end

  always begin
    @(posedge clk); #4;
    if (cop_ce) ce_cnt++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_req = 0; host_we = 0;
  endtask

  task automatic host_rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    @(posedge clk); #1 host_req = 0; #3 d = host_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    #1;
    chk("R1 rst_n low", cop_rst_n, 0);
    chk("R1 ce low", cop_ce, 0);
    host_rd(MODE_A, d); chk("R1 mode read", d, 8'h00);
    host_rd(BANK_A, d); chk("R3 bank reset", d, 8'h00);
    idle(3); chk("R1 still reset", cop_rst_n, 0);
  endtask

  task automatic t_bank();
    logic [7:0] d;
    host_wr(BANK_A, 8'h05); host_rd(BANK_A, d); chk("R3 bank 5", d, 8'h05);
    host_wr(BANK_A, 8'hFF); host_rd(BANK_A, d); chk("R3 bank masked", d, 8'h07);
  endtask

  task automatic t_window();
    logic [7:0] d;
    host_wr(BANK_A, 8'h02);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 16'h6010; host_wdata = 8'hA5;
    #1.5 chk("R2 mapped addr", ram_addr, 16'h4010);
    chk("R2 write strobe", {ram_en, ram_we}, 2'b11);
    @(posedge clk); #1 host_req = 0; host_we = 0;
    host_wr(BANK_A, 8'h07); host_wr(16'h7FFC, 8'h34);
    host_rd(16'h7FFC, d); chk("R2 vector readback", d, 8'h34);
    host_wr(BANK_A, 8'h02); host_rd(16'h6010, d); chk("R2 bank 2 data", d, 8'hA5);
    host_wr(BANK_A, 8'h00); host_wr(16'h6106, 8'h11);
  endtask

  task automatic t_stopped();
    int c0;
    logic [7:0] d;
    host_wr(MODE_A, 8'h01); idle(2);
    chk("R4 reset released", cop_rst_n, 1);
    host_rd(MODE_A, d); chk("R10 stopped read", d, 8'h01);
    @(negedge clk); cop_req = 1; cop_we = 1; cop_addr = 16'h0106; cop_wdata = 8'h55;
    c0 = ce_cnt; idle(10);
    @(negedge clk); cop_req = 0; cop_we = 0;
    chk("R4 no ce stopped", ce_cnt - c0, 0);
    host_rd(16'h6106, d); chk("R4 cop write blocked", d, 8'h11);
    for (int m = 5; m < 8; m++) begin
      host_wr(MODE_A, 8'(m)); c0 = ce_cnt; idle(8);
      chk("R4 unused code idle", ce_cnt - c0, 0);
    end
    host_rd(MODE_A, d); chk("R10 code 7 read", d, 8'h07);
  endtask

  task automatic t_free();
    int c0;
    logic [7:0] d;
    host_wr(MODE_A, 8'h02); idle(1);
    c0 = ce_cnt; idle(20); chk("R5 free ce count", ce_cnt - c0, 20);
    host_rd(MODE_A, d); chk("R10 free read", d, 8'h82);
    @(negedge clk); cop_req = 1; cop_we = 1; cop_addr = 16'h0105; cop_wdata = 8'h77;
    @(negedge clk); cop_we = 0; cop_addr = 16'hFFFC;
    @(posedge clk); #4 chk("R9 vector via cop", cop_rdata, 8'h34);
    @(negedge clk); cop_req = 0;
    host_rd(16'h6105, d); chk("R9 cop write seen", d, 8'h77);
  endtask

  task automatic t_arb();
    @(negedge clk);
    cop_req = 1; cop_addr = 16'h0001;
    host_req = 1; host_we = 0; host_addr = 16'h6020;
    #1.5 chk("R8 ce withheld", cop_ce, 0);
    chk("R8 host owns ram", ram_addr, 16'h0020);
    @(posedge clk); #1 host_req = 0;
    @(negedge clk); host_req = 1; host_addr = MODE_A;
    #1.5 chk("R8 reg access no block", cop_ce, 1);
    @(posedge clk); #1 host_req = 0;
    @(negedge clk); cop_req = 0;
  endtask

  task automatic t_sync();
    int c0;
    host_wr(MODE_A, 8'h03); idle(4);
    c0 = ce_cnt;
    repeat (5) begin
      #50 host_clk = 1; #50 host_clk = 0;
    end
    idle(6);
    chk("R6 one ce per edge", ce_cnt - c0, 5);
  endtask

  task automatic t_step();
    int c0;
    c0 = ce_cnt;
    for (int i = 0; i < 3; i++) begin host_wr(MODE_A, 8'h04); idle(5); end
    idle(15);
    chk("R7 three steps", ce_cnt - c0, 3);
    @(negedge clk); cop_req = 1; cop_addr = 16'h0002;
    c0 = ce_cnt;
    host_wr(MODE_A, 8'h04);
    host_wr(16'h6030, 8'h00);
    idle(10);
    chk("R8 step deferred kept", ce_cnt - c0, 1);
    @(negedge clk); cop_req = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_bank();
    t_window();
    t_stopped();
    t_free();
    t_arb();
    t_sync();
    t_step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule